// File: doc/BRIEF.md
# Two-Wire Serial Byte Memory Slave

This block is a slave on a two-wire serial bus (I2C-style) that fronts an internal byte-wide register array. It samples the bus clock and data lines with the system clock. It recognises Start and Stop conditions and checks the first byte of each transfer against a fixed device-type code and three strap inputs. After that it either takes in a two-byte memory address and data bytes, or streams data bytes out. A single address latch steps forward after every byte, so bursts of any length run through memory in order and wrap from the top address to zero.

Writes go straight into the array as each byte completes. No page buffer is used. A write-protect input guards the upper quarter of the array: a byte aimed there is refused with a NACK, and the address latch stays where it is. The block only ever pulls SDA low through an active-low drive enable. The pad, pull-up and power-on circuitry sit outside the block. The system clock must run at least 8 times faster than SCL. `AW` sets the array size at 2^`AW` bytes. The default is 11, which gives 2048 bytes, and `AW` = 13 gives the full 8192 x 8 organisation. Bus addresses are always 16 bits, and only the low `AW` bits are decoded.

The bus lines carry no valid/ready stream at the edge. Flow control is the bus's own acknowledge bit, and there is no clock stretching. The master can therefore never be back-pressured. A byte the block cannot accept is answered with a NACK.

Top module: `i2cm_slave`

## Requirements
- R1: The first byte after a Start is acknowledged only when bits 7-4 are 1010 and bits 3-1 equal `strap_i[2:0]`. Bit 0 selects read (1) or write (0). Any other byte gets no ACK, and the bus is then ignored until the next Start.
- R2: In write mode, the two bytes after the device byte form a 16-bit address, high byte first. Only the low `AW` bits are used and the higher bits are ignored.
- R3: Each write data byte is stored in the array when its 8th bit is sampled, and it is acknowledged in the slot that follows.
- R4: The address latch advances by one after each byte transferred in either direction. It wraps from 2^`AW`-1 to 0, and bursts have no length limit.
- R5: While `wp_i` is 1, a write data byte aimed at the upper quarter of the array (top two address bits both 1) is not acknowledged, does not change memory, and leaves the address latch unchanged.
- R6: A read starts from the current latched address. A random read is a write-mode device byte plus a two-byte address, then a repeated Start and a read-mode device byte.
- R7: In read mode, a new byte is sent after every master ACK. A master NACK ends the read and leaves SDA released.
- R8: A Start at any point aborts the current operation and restarts device decode. A Stop aborts any operation. A data byte cut off before its 8th bit leaves memory untouched.
- R9: Bits go MSB first. Input bits are taken on the SCL rising edge, and the block changes its SDA drive only while SCL is low.
- R10: `sda_pd_n` is 1 (released) out of reset, in idle, and after Start or Stop. It is 0 only in an ACK slot or for a 0 read-data bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND value) |
| sda_pd_n | output | 1 | Active-low SDA pull-down enable; 1 releases the line |
| wp_i | input | 1 | Write-protect for the upper quarter of the array |
| strap_i | input | 3 | Board strap value that the device byte bits 3-1 must match |

## Verification
Every cycle, the checker confirms that the data drive moves only while the synchronised clock is low. It also confirms that Start and Stop always leave the line released, that every array write is a single-cycle strobe, and that each write advances the address latch by exactly one, wrapping at the top. Other behaviours depend on what comes back over the bus, and only the bench's transfers can show them. These are the refusal of a mismatched device byte, the NACK and held address for protected writes, the discarding of high address bits, the wrap and order of multi-byte bursts, current-address reads, and the survival of memory contents when a byte is cut off by Start or Stop.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_AHI,
    ST_AHI_ACK,
    ST_ALO,
    ST_ALO_ACK,
    ST_WR,
    ST_WR_ACK,
    ST_RD,
    ST_RD_ACK
  } slv_state_t;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int         BYTE_W   = 8;

endpackage

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);

  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;
  logic              scl_s;

  // idle bus level is high, so the chain resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2cm_mem.sv
module i2cm_mem #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) arr[addr] <= wdata;
  end

  assign rdata = arr[addr];

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              sda_s,
  input  logic              wp_i,
  input  logic [2:0]        strap_i,
  input  logic [BYTE_W-1:0] rdata,
  output logic              mem_we,
  output logic [BYTE_W-1:0] mem_wdata,
  output logic [AW-1:0]     cur_addr,
  output logic              sda_pd_n
);

  localparam int            HI_W = AW - BYTE_W;
  localparam logic [AW-1:0] ONE  = AW'(1);

  slv_state_t        st;
  logic [2:0]        cnt;
  logic [6:0]        sh;
  logic [HI_W-1:0]   hi_q;
  logic              ack_q;
  logic              ackph;
  logic              rw_q;
  logic [7:0]        byte_in;
  logic              last_bit;
  logic              prot;
  logic              dev_hit;

  assign byte_in  = {sh, sda_s};
  assign last_bit = scl_rise && (cnt == 3'd7);
  assign prot     = wp_i && (cur_addr[AW-1:AW-2] == 2'b11);
  assign dev_hit  = (byte_in[7:4] == DEV_TYPE) && (byte_in[3:1] == strap_i);

  always_comb begin
    mem_we    = (st == ST_WR) && last_bit && !prot && !bus_start && !bus_stop;
    mem_wdata = byte_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      sh       <= '0;
      hi_q     <= '0;
      ack_q    <= 1'b0;
      ackph    <= 1'b0;
      rw_q     <= 1'b0;
      cur_addr <= '0;
      sda_pd_n <= 1'b1;
    end else if (bus_start) begin
      st       <= ST_DEV;
      cnt      <= '0;
      ackph    <= 1'b0;
      sda_pd_n <= 1'b1;
    end else if (bus_stop) begin
      st       <= ST_IDLE;
      ackph    <= 1'b0;
      sda_pd_n <= 1'b1;
    end else begin
      case (st)
        ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
          if (scl_rise) begin
            sh  <= byte_in[6:0];
            cnt <= cnt + 3'd1;
          end
          if (last_bit) begin
            ack_q <= 1'b1;
            case (st)
              ST_DEV: begin
                rw_q <= byte_in[0];
                st   <= dev_hit ? ST_DEV_ACK : ST_IDLE;
              end
              ST_AHI: begin
                hi_q <= byte_in[HI_W-1:0];
                st   <= ST_AHI_ACK;
              end
              ST_ALO: begin
                cur_addr <= {hi_q, byte_in};
                st       <= ST_ALO_ACK;
              end
              default: begin
                if (prot) ack_q <= 1'b0;
                else      cur_addr <= cur_addr + ONE;
                st <= ST_WR_ACK;
              end
            endcase
          end
        end

        ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WR_ACK: begin
          if (scl_fall) begin
            if (!ackph) begin
              ackph    <= 1'b1;
              sda_pd_n <= ~ack_q;
            end else begin
              ackph    <= 1'b0;
              sda_pd_n <= 1'b1;
              cnt      <= '0;
              case (st)
                ST_DEV_ACK: begin
                  if (rw_q) begin
                    sh       <= rdata[6:0];
                    sda_pd_n <= rdata[7];
                    st       <= ST_RD;
                  end else begin
                    st <= ST_AHI;
                  end
                end
                ST_AHI_ACK: st <= ST_ALO;
                ST_ALO_ACK: st <= ST_WR;
                default:    st <= ack_q ? ST_WR : ST_IDLE;
              endcase
            end
          end
        end

        ST_RD: begin
          if (scl_fall) begin
            sh       <= {sh[5:0], 1'b0};
            sda_pd_n <= sh[6];
          end
          if (scl_rise) begin
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) begin
              cur_addr <= cur_addr + ONE;
              st       <= ST_RD_ACK;
            end
          end
        end

        ST_RD_ACK: begin
          if (scl_rise && ackph) ack_q <= ~sda_s;
          if (scl_fall) begin
            if (!ackph) begin
              ackph    <= 1'b1;
              sda_pd_n <= 1'b1;
            end else begin
              ackph <= 1'b0;
              cnt   <= '0;
              if (ack_q) begin
                sh       <= rdata[6:0];
                sda_pd_n <= rdata[7];
                st       <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
        end

        default: ;
      endcase
    end
  end

endmodule

// File: rtl/i2cm_slave.sv
module i2cm_slave
  import i2cm_pkg::*;
#(
  parameter int AW      = 11,
  parameter int SYNC_FF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pd_n,
  input  logic       wp_i,
  input  logic [2:0] strap_i
);

  logic              sda_s;
  logic              scl_rise;
  logic              scl_fall;
  logic              bus_start;
  logic              bus_stop;
  logic              mem_we;
  logic [BYTE_W-1:0] mem_wdata;
  logic [BYTE_W-1:0] mem_rdata;
  logic [AW-1:0]     cur_addr;

  i2cm_sync #(.STAGES(SYNC_FF)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop)
  );

  i2cm_ctrl #(.AW(AW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .bus_start (bus_start),
    .bus_stop  (bus_stop),
    .sda_s     (sda_s),
    .wp_i      (wp_i),
    .strap_i   (strap_i),
    .rdata     (mem_rdata),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .cur_addr  (cur_addr),
    .sda_pd_n  (sda_pd_n)
  );

  i2cm_mem #(.AW(AW), .DW(BYTE_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .addr  (cur_addr),
    .wdata (mem_wdata),
    .rdata (mem_rdata)
  );

endmodule

// File: rtl/i2cm_slave_chk.sv
module i2cm_slave_chk #(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_rise,
  input logic          scl_fall,
  input logic          bus_start,
  input logic          bus_stop,
  input logic          sda_pd_n,
  input logic          mem_we,
  input logic [AW-1:0] cur_addr
);

  localparam logic [AW-1:0] ONE = AW'(1);

  // own record of the synchronised clock level, rebuilt from the edge strobes
  logic scl_lvl;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        scl_lvl <= 1'b1;
    else if (scl_rise) scl_lvl <= 1'b1;
    else if (scl_fall) scl_lvl <= 1'b0;
  end

  p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> sda_pd_n);

  p_start_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> sda_pd_n);

  p_drive_scl_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_pd_n) && !$past(bus_start) && !$past(bus_stop)) |-> !scl_lvl);

  p_we_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (cur_addr == $past(cur_addr) + ONE));

endmodule

bind i2cm_slave i2cm_slave_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_rise  (scl_rise),
  .scl_fall  (scl_fall),
  .bus_start (bus_start),
  .bus_stop  (bus_stop),
  .sda_pd_n  (sda_pd_n),
  .mem_we    (mem_we),
  .cur_addr  (cur_addr)
);

// File: tb/i2cm_slave_tb.sv
module i2cm_slave_tb;

  localparam int         Q     = 6;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] DEV_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] DEV_R = {4'b1010, STRAP, 1'b1};

  typedef struct packed {
    logic [15:0] wa;
    logic [7:0]  wd;
    logic        wp;
    logic        ack;
    logic [15:0] ra;
    logic [7:0]  rd;
  } vec_t;

  // write one byte, expect ack, then read back from ra (AW = 11, protected 600h-7FFh)
  localparam vec_t VEC [9] = '{
    '{16'h0010, 8'h11, 1'b0, 1'b1, 16'h0010, 8'h11},
    '{16'h0011, 8'hA5, 1'b1, 1'b1, 16'h0011, 8'hA5},
    '{16'h0700, 8'h5A, 1'b0, 1'b1, 16'h0700, 8'h5A},
    '{16'h0700, 8'hC3, 1'b1, 1'b0, 16'h0700, 8'h5A},
    '{16'h05FF, 8'h3C, 1'b1, 1'b1, 16'h05FF, 8'h3C},
    '{16'h0600, 8'h99, 1'b0, 1'b1, 16'h0600, 8'h99},
    '{16'h0600, 8'h77, 1'b1, 1'b0, 16'h0600, 8'h99},
    '{16'hF812, 8'hE1, 1'b0, 1'b1, 16'h0012, 8'hE1},
    '{16'h07FF, 8'h42, 1'b0, 1'b1, 16'h07FF, 8'h42}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       wp = 1'b0;
  logic       sda_pd_n;
  logic       sda_bus;
  int         n_tests = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  assign sda_bus = sda_m & sda_pd_n;

  always #4 clk = ~clk;

  i2cm_slave u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl),
    .sda_i    (sda_bus),
    .sda_pd_n (sda_pd_n),
    .wp_i     (wp),
    .strap_i  (STRAP)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b0; tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic do_stop();
    sda_m = 1'b0; tick(Q);
    scl = 1'b1;   tick(Q);
    sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b;  tick(Q);
    scl = 1'b1; tick(2*Q);
    scl = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl = 1'b1;   tick(Q);
    b = sda_bus;  tick(Q);
    scl = 1'b0;   tick(Q);
  endtask

  task automatic put_bits(input logic [7:0] b, input int n);
    for (int k = 7; k > 7 - n; k--) put_bit(b[k]);
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    logic a;
    put_bits(b, 8);
    get_bit(a);
    ack = ~a;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic mack);
    logic b;
    for (int k = 7; k >= 0; k--) begin
      get_bit(b);
      d[k] = b;
    end
    put_bit(~mack);
  endtask

  task automatic addr_phase(input logic [15:0] a, output logic ok);
    logic a0, a1, a2;
    do_start();
    wbyte(DEV_W, a0);
    wbyte(a[15:8], a1);
    wbyte(a[7:0], a2);
    ok = a0 & a1 & a2;
  endtask

  task automatic rd_random(input logic [15:0] a, output logic [7:0] d);
    logic ok, ar;
    addr_phase(a, ok);
    do_start();
    wbyte(DEV_R, ar);
    rbyte(d, 1'b0);
    do_stop();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R7 actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    logic       ok, ack, a1, a2, a3;
    logic [7:0] d, d0, d1, d2;

    tick(5);
    rst_n = 1'b1;
    tick(5);
    check(sda_pd_n == 1'b1, "R10 reset release", int'(sda_pd_n), 1);

    // table walk: single writes with and without protect, then random read
    for (int i = 0; i < 9; i++) begin
      wp = VEC[i].wp;
      addr_phase(VEC[i].wa, ok);
      wbyte(VEC[i].wd, ack);
      do_stop();
      check(ok && (ack == VEC[i].ack), "R2,R3,R5 write ack", int'(ack), int'(VEC[i].ack));
      wp = 1'b0;
      rd_random(VEC[i].ra, d);
      check(d == VEC[i].rd, "R6,R9 readback", int'(d), int'(VEC[i].rd));
    end

    // R1: wrong strap, then bytes that must be ignored
    do_start();
    wbyte(8'hA0, a1);
    wbyte(8'h00, a2);
    wbyte(8'h10, a3);
    wbyte(8'hFF, ack);
    do_stop();
    check(!(a1 | a2 | a3 | ack), "R1 mismatch ignored", int'({a1, a2, a3, ack}), 0);
    rd_random(16'h0010, d);
    check(d == 8'h11, "R1 memory untouched", int'(d), 8'h11);
    do_start();
    wbyte(8'h2A, ack);
    do_stop();
    check(!ack, "R1 wrong type nack", int'(ack), 0);

    // R4/R7: burst write across the wrap, burst read back
    addr_phase(16'h07FE, ok);
    wbyte(8'h01, a1);
    wbyte(8'h02, a2);
    wbyte(8'h03, a3);
    do_stop();
    check(ok & a1 & a2 & a3, "R4 burst write acks", int'({a1, a2, a3}), 7);
    addr_phase(16'h07FE, ok);
    do_start();
    wbyte(DEV_R, ack);
    rbyte(d0, 1'b1);
    rbyte(d1, 1'b1);
    rbyte(d2, 1'b0);
    check(sda_pd_n == 1'b1, "R7 release after nack", int'(sda_pd_n), 1);
    do_stop();
    check(d0 == 8'h01, "R7 burst byte0", int'(d0), 8'h01);
    check(d1 == 8'h02, "R4 byte at top", int'(d1), 8'h02);
    check(d2 == 8'h03, "R4 wrapped to zero", int'(d2), 8'h03);

    // R5: protected write leaves address latch in place
    wp = 1'b1;
    addr_phase(16'h0700, ok);
    wbyte(8'hEE, ack);
    do_stop();
    wp = 1'b0;
    check(!ack, "R5 protected nack", int'(ack), 0);
    do_start();
    wbyte(DEV_R, ack);
    rbyte(d, 1'b0);
    do_stop();
    check(d == 8'h5A, "R5 address held", int'(d), 8'h5A);

    // R8: Stop inside a byte
    addr_phase(16'h0021, ok);
    wbyte(8'h66, ack);
    do_stop();
    addr_phase(16'h0020, ok);
    wbyte(8'h11, ack);
    put_bits(8'hFF, 5);
    do_stop();
    rd_random(16'h0021, d);
    check(d == 8'h66, "R8 stop abort", int'(d), 8'h66);
    rd_random(16'h0020, d);
    check(d == 8'h11, "R3 full byte kept", int'(d), 8'h11);

    // R8/R6: repeated Start inside a byte, then current-address read
    addr_phase(16'h0020, ok);
    wbyte(8'h11, ack);
    put_bits(8'h00, 4);
    do_start();
    wbyte(DEV_R, ack);
    check(ack, "R1 read device ack", int'(ack), 1);
    rbyte(d, 1'b0);
    do_stop();
    check(d == 8'h66, "R8 start abort R6 current address", int'(d), 8'h66);

    tick(4);
    check(sda_pd_n == 1'b1, "R10 idle release", int'(sda_pd_n), 1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule